// File: doc/BRIEF.md
# Vector mask population count and find-first

This unit takes two packed bit vectors from a vector datapath, a source mask and an enable mask, together with the active vector length and the resume index of the issuing instruction. It returns one 32-bit scalar. In count mode the scalar is the number of elements that are both enabled and set. In first mode it is the index of the lowest such element, or all-ones if there is none.

The operands are latched when a start is accepted. The combined active bits are then scanned one fixed-width chunk per clock. A one-cycle done pulse carries the result. A nonzero resume index is not supported: such a request is answered on the very next cycle with a trap flag and a zero result, and nothing is scanned.

Chunk width and maximum element count are parameters. Latency therefore trades directly against the width of the per-chunk adder and priority logic.

Top module: `vmask_scan`

## Requirements
- R1: Element i is bit i of each packed mask input, which is bit (i mod 8) of byte (i div 8).
- R2: An element counts, or can be found, only when its source bit and its enable bit are both 1.
- R3: In count mode (`mode` = 0) the result is the number of qualifying elements with index below `vl`.
- R4: In first mode (`mode` = 1) the result is the smallest qualifying index below `vl`, or 32'hFFFF_FFFF when there is none.
- R5: Mask bits at indices at or above `vl` have no effect on either result.
- R6: With `vl` = 0, count mode returns 0 and first mode returns 32'hFFFF_FFFF.
- R7: A start with nonzero `vstart` yields `done` = 1, `exc` = 1 and `result` = 0 on the cycle after the start edge, with no scan.
- R8: A start with `vstart` = 0 yields a single-cycle `done` with `exc` = 0 exactly VLMAX/CHUNK + 1 cycles after the start edge.
- R9: A start raised while a scan is in progress is ignored; the running scan completes with its own latched operands.
- R10: After reset, `done`, `exc` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a scan; accepted only when idle |
| mode | input | 1 | 0 = count, 1 = first index |
| vl | input | $clog2(VLMAX+1) | Active vector length, at most VLMAX |
| vstart | input | VSW | Resume index; must be 0 for a real scan |
| src_mask | input | VLMAX | Packed source mask, one bit per element |
| en_mask | input | VLMAX | Packed enable mask, one bit per element |
| done | output | 1 | One-cycle completion pulse |
| exc | output | 1 | Trap flag, valid with done |
| result | output | 32 | Scalar result, valid with done |

## Verification
The assertions assume that `vl` never exceeds VLMAX when a start is accepted. They also assume that the range checks on the result are meaningful only for non-trapping completions. The stimulus derives every `vl` with a modulus that keeps it within 0..VLMAX. The bench runs with a small configuration of twelve elements in three chunks, which makes sweeping every source pattern and every enable pattern affordable. Trap requests are sent only with nonzero resume values, and the busy-start case is driven only while a scan is known to be running.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  typedef enum logic {
    SCAN_COUNT = 1'b0,
    SCAN_FIRST = 1'b1
  } scan_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } scan_state_e;

  localparam logic [31:0] NONE_FOUND = 32'hFFFF_FFFF;
endpackage

// File: rtl/vmask_len_mask.sv
module vmask_len_mask #(
  parameter int VLMAX = 256,
  parameter int LW    = $clog2(VLMAX + 1)
) (
  input  logic [LW-1:0]    vl,
  output logic [VLMAX-1:0] keep
);
  for (genvar g = 0; g < VLMAX; g++) begin : g_keep
    assign keep[g] = (LW'(g) < vl);
  end
endmodule

// File: rtl/vmask_chunk_eval.sv
module vmask_chunk_eval #(
  parameter int CHUNK = 32,
  parameter int CW    = $clog2(CHUNK + 1),
  parameter int IW    = (CHUNK > 1) ? $clog2(CHUNK) : 1
) (
  input  logic [CHUNK-1:0] bits,
  output logic [CW-1:0]    cnt,
  output logic             any,
  output logic [IW-1:0]    first
);
  always_comb begin
    cnt   = '0;
    first = '0;
    for (int i = 0; i < CHUNK; i++) begin
      cnt = cnt + CW'(bits[i]);
    end
    for (int i = CHUNK - 1; i >= 0; i--) begin
      if (bits[i]) first = IW'(i);
    end
    any = |bits;
  end
endmodule

// File: rtl/vmask_scan.sv
module vmask_scan #(
  parameter int VLMAX = 256,
  parameter int CHUNK = 32,
  parameter int VSW   = 16,
  localparam int LW   = $clog2(VLMAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [LW-1:0]    vl,
  input  logic [VSW-1:0]   vstart,
  input  logic [VLMAX-1:0] src_mask,
  input  logic [VLMAX-1:0] en_mask,
  output logic             done,
  output logic             exc,
  output logic [31:0]      result
);
  import vmask_pkg::*;

  localparam int NCHUNK = VLMAX / CHUNK;
  localparam int NCW    = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
  localparam int CW     = $clog2(CHUNK + 1);
  localparam int IW     = (CHUNK > 1) ? $clog2(CHUNK) : 1;

  scan_state_e       state_q;
  scan_mode_e        mode_q;
  logic [VLMAX-1:0]  act_q;
  logic [NCW-1:0]    cidx_q;
  logic [31:0]       base_q;
  logic [31:0]       cnt_acc_q;
  logic              found_q;
  logic [31:0]       first_q;
  logic [LW-1:0]     vl_q;

  logic [VLMAX-1:0]  keep;
  logic [CW-1:0]     c_cnt;
  logic              c_any;
  logic [IW-1:0]     c_first;

  logic [31:0]       nxt_cnt;
  logic              nxt_found;
  logic [31:0]       nxt_first;
  logic              last_chunk;
  logic              accept;

  vmask_len_mask #(.VLMAX(VLMAX), .LW(LW)) u_len (
    .vl   (vl),
    .keep (keep)
  );

  vmask_chunk_eval #(.CHUNK(CHUNK), .CW(CW), .IW(IW)) u_eval (
    .bits  (act_q[CHUNK-1:0]),
    .cnt   (c_cnt),
    .any   (c_any),
    .first (c_first)
  );

  assign accept     = start && (state_q == ST_IDLE);
  assign last_chunk = (cidx_q == NCW'(NCHUNK - 1));

  always_comb begin
    nxt_cnt   = cnt_acc_q + 32'(c_cnt);
    nxt_found = found_q | c_any;
    nxt_first = found_q ? first_q : (base_q + 32'(c_first));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mode_q    <= SCAN_COUNT;
      act_q     <= '0;
      cidx_q    <= '0;
      base_q    <= '0;
      cnt_acc_q <= '0;
      found_q   <= 1'b0;
      first_q   <= '0;
      vl_q      <= '0;
      done      <= 1'b0;
      exc       <= 1'b0;
      result    <= '0;
    end else begin
      done <= 1'b0;
      exc  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (vstart != '0) begin
              done   <= 1'b1;
              exc    <= 1'b1;
              result <= '0;
            end else begin
              act_q     <= src_mask & en_mask & keep;
              mode_q    <= scan_mode_e'(mode);
              vl_q      <= vl;
              cidx_q    <= '0;
              base_q    <= '0;
              cnt_acc_q <= '0;
              found_q   <= 1'b0;
              first_q   <= '0;
              state_q   <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          act_q     <= act_q >> CHUNK;
          cidx_q    <= cidx_q + 1'b1;
          base_q    <= base_q + 32'(CHUNK);
          cnt_acc_q <= nxt_cnt;
          found_q   <= nxt_found;
          first_q   <= nxt_first;
          if (last_chunk) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
            if (mode_q == SCAN_FIRST) result <= nxt_found ? nxt_first : NONE_FOUND;
            else                      result <= nxt_cnt;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_VL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    accept |-> (32'(vl) <= 32'(VLMAX)));  // R3

  AST_TRAP_NEXT: assert property (@(posedge clk) disable iff (rst)
    (accept && vstart != '0) |=> (done && exc && result == 32'd0));  // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (done && !exc && mode_q == SCAN_COUNT) |-> (result <= 32'(vl_q)));  // R5

  AST_FIRST_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done && !exc && mode_q == SCAN_FIRST && result != NONE_FOUND) |-> (result < 32'(vl_q)));  // R4

  AST_QUIET_MID_SCAN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !last_chunk) |=> !done);  // R8
endmodule

// File: tb/vmask_scan_test.sv
module vmask_scan_test;
  localparam int VLMAX = 12;
  localparam int CHUNK = 4;
  localparam int VSW   = 16;
  localparam int LW    = $clog2(VLMAX + 1);
  localparam int LAT   = VLMAX / CHUNK + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             mode = 1'b0;
  logic [LW-1:0]    vl = '0;
  logic [VSW-1:0]   vstart = '0;
  logic [VLMAX-1:0] src_mask = '0;
  logic [VLMAX-1:0] en_mask = '0;
  logic             done;
  logic             exc;
  logic [31:0]      result;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vmask_scan #(.VLMAX(VLMAX), .CHUNK(CHUNK), .VSW(VSW)) uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .vl(vl),
    .vstart(vstart), .src_mask(src_mask), .en_mask(en_mask),
    .done(done), .exc(exc), .result(result)
  );

  function automatic logic [31:0] model(input logic m, input int len,
                                        input logic [VLMAX-1:0] s,
                                        input logic [VLMAX-1:0] e);
    logic [31:0] cnt = 0;
    for (int i = VLMAX - 1; i >= 0; i--) begin
      if (i < len && s[i] && e[i]) begin
        if (m) return_first: cnt = i;
        else cnt = cnt + 1;
      end
    end
    if (m) begin
      cnt = 32'hFFFF_FFFF;
      for (int i = VLMAX - 1; i >= 0; i--)
        if (i < len && s[i] && e[i]) cnt = i;
    end
    return cnt;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic m, input int len, input logic [VSW-1:0] vs,
                        input logic [VLMAX-1:0] s, input logic [VLMAX-1:0] e,
                        output logic [31:0] res, output logic ex, output int lat);
    mode = m; vl = LW'(len); vstart = vs; src_mask = s; en_mask = e;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    res = result;
    ex  = exc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic scan_check(input string tag, input logic m, input int len,
                            input logic [VLMAX-1:0] s, input logic [VLMAX-1:0] e);
    logic [31:0] res;
    logic ex;
    int lat;
    logic [31:0] exp;
    exp = model(m, len, s, e);
    run_op(m, len, '0, s, e, res, ex, lat);
    check(res == exp && !ex && lat == LAT, tag, res, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check(done == 1'b0 && exc == 1'b0 && result == 32'd0, "R10", {result[29:0], done, exc}, 32'd0);

    begin : directed
      logic [31:0] res;
      logic ex;
      int lat;
      // R1: element 5 is byte 0 bit 5; element 9 is byte 1 bit 1
      scan_check("R1", 1'b1, 12, 12'h020, 12'hFFF);
      scan_check("R1", 1'b1, 12, 12'h200, 12'hFFF);
      // R2: source set only where enable clear gives nothing
      scan_check("R2", 1'b0, 12, 12'h0F0, 12'hF0F);
      scan_check("R2", 1'b1, 12, 12'hFF0, 12'h0C0);
      // R5: bits at and above vl ignored
      scan_check("R5", 1'b0, 5, 12'hFFF, 12'hFFF);
      scan_check("R5", 1'b1, 5, 12'hFE0, 12'hFFF);
      // R6: zero length
      scan_check("R6", 1'b0, 0, 12'hFFF, 12'hFFF);
      scan_check("R6", 1'b1, 0, 12'hFFF, 12'hFFF);
      // R3 and R4 at the full-length boundary
      scan_check("R3", 1'b0, 12, 12'hFFF, 12'hFFF);
      scan_check("R4", 1'b1, 12, 12'h800, 12'h800);
      // R7: nonzero vstart traps on the next cycle
      run_op(1'b0, 12, 16'd1, 12'hFFF, 12'hFFF, res, ex, lat);
      check(ex && res == 32'd0 && lat == 1, "R7", res, 32'd0);
      run_op(1'b1, 0, 16'h8000, 12'h001, 12'h001, res, ex, lat);
      check(ex && res == 32'd0 && lat == 1, "R7", {res[30:0], ex}, 32'd1);
      // R8: latency and single-cycle done
      run_op(1'b0, 12, '0, 12'h00F, 12'h0FF, res, ex, lat);
      check(lat == LAT && res == 32'd4 && !ex, "R8", 32'(lat), 32'(LAT));
    end

    // R9: start while busy is ignored
    begin : busy
      int lat;
      int dones;
      mode = 1'b0; vl = LW'(12); vstart = '0; src_mask = 12'h0FF; en_mask = 12'hFFF;
      start = 1'b1;
      @(posedge clk); @(negedge clk);
      mode = 1'b1; src_mask = 12'h001; vstart = 16'd3;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      lat = 2;
      while (!done && lat < 40) begin
        @(posedge clk); @(negedge clk); lat++;
      end
      check(result == 32'd8 && !exc && lat == LAT, "R9", result, 32'd8);
      dones = 0;
      repeat (6) begin
        @(posedge clk); @(negedge clk);
        if (done) dones++;
      end
      check(dones == 0, "R9", 32'(dones), 32'd0);
    end

    // R3/R4 sweep: every source pattern, both modes, varied length
    for (int s = 0; s < 4096; s++) begin
      scan_check("R3", 1'b0, s % 13, 12'(s), 12'hFFF);
      scan_check("R4", 1'b1, (s * 7) % 13, 12'(s), 12'hFFF);
    end
    // R2 sweep: every enable pattern against a fixed source
    for (int e = 0; e < 4096; e++) begin
      scan_check("R2", e[0], 12 - (e % 5), 12'hB6D, 12'(e));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule